// File: doc/BRIEF.md
# Programmable Memory Timing Sequencer

This block drives the control lines of a memory whose timing is too irregular for a fixed state machine, such as a DRAM with multiplexed row and column addresses. The timing comes from a small pattern store that the host fills in beforehand. Each stored word is one clock's worth of control. It sets a group of general-purpose control lines, the address-multiplexer select and a hold request back to the host bus.

Four routines live in the store. They serve ordinary single accesses, burst accesses, refresh events and exception handling, and each has its own fixed start location. A request strobe launches a routine while the sequencer is idle. The sequencer then steps through consecutive locations, one per clock, until it applies a word that carries the end-of-routine flag. The refresh request comes from a timer outside the block.

The host fills the store through a plain write port. The store is locked while a routine runs: a write during a run is dropped and answered with a one-cycle reject pulse.

Top module: `mem_pattern_seq`

## Requirements
- R1: During reset and in the first idle cycle after it, `seq_busy`, `ctl_lines`, `addr_mux_sel`, `host_hold`, `route` and `wr_reject` are all 0, and every store location reads as 0.
- R2: While idle, `ctl_lines`, `addr_mux_sel`, `host_hold` and `route` are 0 whatever the store holds.
- R3: A request seen at a clock edge while idle makes `seq_busy` 1 in the next cycle, and the outputs then show the word at that routine's start location: normal 0, burst 8, refresh 48, exception 60.
- R4: When several requests arrive together, exception wins over refresh, refresh over burst, and burst over normal.
- R5: Each word is applied for exactly one cycle, and the next cycle applies the word at the next location. Word layout: bits 4..0 go to `ctl_lines`, bit 5 to `addr_mux_sel` and bit 6 to `host_hold`. Bit 7 is the end-of-routine flag. Bits 31..8 have no effect.
- R6: The cycle after a word with bit 7 set has been applied, `seq_busy` is 0.
- R7: A request that arrives while a routine runs neither restarts nor redirects it and is not remembered afterwards.
- R8: A routine that reaches location 63 without an end flag stops after applying location 63, so the exception routine then lasts four cycles.
- R9: A write with `wr_en` high while idle stores `wr_data` at `wr_addr`. A write in the same cycle as a request is stored before the routine reads the store.
- R10: A write attempted while busy leaves the store unchanged, and `wr_reject` is 1 for exactly the following cycle. At all other times `wr_reject` is 0.
- R11: While busy, `route` shows the running routine: 0 normal, 1 burst, 2 refresh, 3 exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | 6 | Store write location |
| wr_data | input | 32 | Store write word |
| req_normal | input | 1 | Start the single-access routine |
| req_burst | input | 1 | Start the burst routine |
| req_refresh | input | 1 | Start the refresh routine |
| req_except | input | 1 | Start the exception routine |
| ctl_lines | output | 5 | General-purpose control lines |
| addr_mux_sel | output | 1 | Address multiplexer select |
| host_hold | output | 1 | Hold the host bus cycle |
| seq_busy | output | 1 | A routine is running |
| route | output | 2 | Code of the running routine |
| wr_reject | output | 1 | Previous-cycle write was dropped |

## Verification
Each routine is loaded with a different length and different bit patterns, so a wrong start location or a wrong step shows up in the output values as well as in the run length. Requests are sent alone and in overlapping groups, which separates the four priority levels. Requests raised in the middle of a run show whether a run can be redirected or whether a request is remembered. A write is made during a run to a location the normal routine reads, and another write lands in the same cycle as a request, so both the store lock and the order of write and read are visible at the outputs. The exception routine has no end flag, so it exercises the stop at the top of the store.

// File: rtl/mps_pkg.sv
package mps_pkg;

   typedef enum logic [1:0] {
      RT_NORMAL  = 2'd0,
      RT_BURST   = 2'd1,
      RT_REFRESH = 2'd2,
      RT_EXCEPT  = 2'd3
   } route_e;

   localparam int unsigned NUM_ROUTES = 4;

endpackage

// File: rtl/mps_pattern_ram.sv
module mps_pattern_ram #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic              wr_reject
);

   logic [WORD_W-1:0] store_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) begin
            store_q[i] <= '0;
         end
         wr_reject <= 1'b0;
      end else begin
         wr_reject <= wr_en && lock;
         if (wr_en && !lock) begin
            store_q[wr_addr] <= wr_data;
         end
      end
   end

   assign rd_data = store_q[rd_addr];

endmodule

// File: rtl/mps_arbiter.sv
module mps_arbiter #(
   parameter int unsigned N  = 4,
   parameter int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          grant_valid,
   output logic [IW-1:0] grant_idx
);

   // Higher index means higher priority: the loop lets later hits overwrite.
   always_comb begin
      grant_valid = 1'b0;
      grant_idx   = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (req[i]) begin
            grant_valid = 1'b1;
            grant_idx   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/mps_stepper.sv
module mps_stepper #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned AW    = $clog2(DEPTH),
   parameter int unsigned RW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [RW-1:0] start_route,
   input  logic [AW-1:0] start_addr,
   input  logic          word_last,
   output logic          busy,
   output logic [AW-1:0] pc,
   output logic [RW-1:0] route
);

   localparam logic [AW-1:0] TOP_LOC = AW'(DEPTH - 1);

   logic finish;
   assign finish = word_last || (pc == TOP_LOC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         pc    <= '0;
         route <= '0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            pc    <= start_addr;
            route <= start_route;
         end
      end else if (finish) begin
         busy  <= 1'b0;
         pc    <= '0;
         route <= '0;
      end else begin
         pc <= pc + AW'(1);
      end
   end

endmodule

// File: rtl/mps_decode.sv
module mps_decode #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned GPO_W  = 5
) (
   input  logic              active,
   input  logic [WORD_W-1:0] word,
   output logic [GPO_W-1:0]  gpo,
   output logic              amux,
   output logic              hold,
   output logic              last
);

   localparam int unsigned AMUX_BIT = GPO_W;
   localparam int unsigned HOLD_BIT = GPO_W + 1;
   localparam int unsigned LAST_BIT = GPO_W + 2;

   for (genvar g = 0; g < int'(GPO_W); g++) begin : g_gpo
      assign gpo[g] = active & word[g];
   end

   assign amux = active & word[AMUX_BIT];
   assign hold = active & word[HOLD_BIT];
   assign last = active & word[LAST_BIT];

   if (WORD_W > LAST_BIT + 1) begin : g_rsvd
      logic rsvd_unused;
      assign rsvd_unused = ^word[WORD_W-1:LAST_BIT+1];
   end

endmodule

// File: rtl/mem_pattern_seq.sv
module mem_pattern_seq #(
   parameter int unsigned DEPTH       = 64,
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned GPO_W       = 5,
   parameter int unsigned OFS_NORMAL  = 0,
   parameter int unsigned OFS_BURST   = 8,
   parameter int unsigned OFS_REFRESH = 48,
   parameter int unsigned OFS_EXCEPT  = 60,
   parameter int unsigned AW          = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              req_normal,
   input  logic              req_burst,
   input  logic              req_refresh,
   input  logic              req_except,
   output logic [GPO_W-1:0]  ctl_lines,
   output logic              addr_mux_sel,
   output logic              host_hold,
   output logic              seq_busy,
   output logic [1:0]        route,
   output logic              wr_reject
);

   import mps_pkg::*;

   localparam int unsigned NR = NUM_ROUTES;
   localparam int unsigned RW = $clog2(NR);

   if (DEPTH != (1 << AW)) begin : g_chk_depth
      $error("DEPTH must be a power of two");
   end
   if (GPO_W + 3 > WORD_W) begin : g_chk_width
      $error("word too narrow for control fields");
   end
   if (OFS_NORMAL >= DEPTH || OFS_BURST >= DEPTH ||
       OFS_REFRESH >= DEPTH || OFS_EXCEPT >= DEPTH) begin : g_chk_ofs
      $error("start offset outside pattern store");
   end
   if (RW != 2) begin : g_chk_rw
      $error("route code must be two bits");
   end

   logic [NR-1:0]     req_vec;
   logic              req_any;
   logic [RW-1:0]     grant_idx;
   logic [AW-1:0]     start_addr;
   logic [AW-1:0]     pc_q;
   logic [RW-1:0]     route_q;
   logic [WORD_W-1:0] cur_word;
   logic              word_last;

   assign req_vec[RT_NORMAL]  = req_normal;
   assign req_vec[RT_BURST]   = req_burst;
   assign req_vec[RT_REFRESH] = req_refresh;
   assign req_vec[RT_EXCEPT]  = req_except;

   mps_arbiter #(.N(NR), .IW(RW)) u_arb (
      .req         (req_vec),
      .grant_valid (req_any),
      .grant_idx   (grant_idx)
   );

   always_comb begin
      unique case (route_e'(grant_idx))
         RT_BURST:   start_addr = AW'(OFS_BURST);
         RT_REFRESH: start_addr = AW'(OFS_REFRESH);
         RT_EXCEPT:  start_addr = AW'(OFS_EXCEPT);
         default:    start_addr = AW'(OFS_NORMAL);
      endcase
   end

   mps_pattern_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW)) u_ram (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock      (seq_busy),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (pc_q),
      .rd_data   (cur_word),
      .wr_reject (wr_reject)
   );

   mps_stepper #(.DEPTH(DEPTH), .AW(AW), .RW(RW)) u_step (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (req_any),
      .start_route (grant_idx),
      .start_addr  (start_addr),
      .word_last   (word_last),
      .busy        (seq_busy),
      .pc          (pc_q),
      .route       (route_q)
   );

   mps_decode #(.WORD_W(WORD_W), .GPO_W(GPO_W)) u_dec (
      .active (seq_busy),
      .word   (cur_word),
      .gpo    (ctl_lines),
      .amux   (addr_mux_sel),
      .hold   (host_hold),
      .last   (word_last)
   );

   assign route = route_q;

endmodule

// File: rtl/mps_checker.sv
module mps_checker #(
   parameter int unsigned AW    = 6,
   parameter int unsigned GPO_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             seq_busy,
   input logic             wr_en,
   input logic             wr_reject,
   input logic             req_any,
   input logic             word_last,
   input logic [AW-1:0]    pc_q,
   input logic [1:0]       route,
   input logic [GPO_W-1:0] ctl_lines,
   input logic             addr_mux_sel,
   input logic             host_hold
);

   localparam logic [AW-1:0] TOP_LOC = '1;

   // R2: idle outputs quiet
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_busy |-> (ctl_lines == '0 && !addr_mux_sel && !host_hold && route == 2'd0));

   // R3: request in idle starts a run
   a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_busy && req_any) |=> seq_busy);

   // R5: one location per cycle
   a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && !word_last && pc_q != TOP_LOC) |=> (seq_busy && pc_q == $past(pc_q) + AW'(1)));

   // R6: end flag returns to idle
   a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && word_last) |=> !seq_busy);

   // R7: route held through a run
   a_r7_route_held: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && !word_last && pc_q != TOP_LOC) |=> $stable(route));

   // R8: stop at top location
   a_r8_top_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && pc_q == TOP_LOC) |=> !seq_busy);

   // R10: reject pulse exactly after a busy write
   a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && wr_en) |=> wr_reject);
   a_r10_no_reject: assert property (@(posedge clk) disable iff (!rst_n)
      !(seq_busy && wr_en) |=> !wr_reject);

endmodule

bind mem_pattern_seq mps_checker #(.AW(AW), .GPO_W(GPO_W)) u_mps_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .seq_busy     (seq_busy),
   .wr_en        (wr_en),
   .wr_reject    (wr_reject),
   .req_any      (req_any),
   .word_last    (word_last),
   .pc_q         (pc_q),
   .route        (route),
   .ctl_lines    (ctl_lines),
   .addr_mux_sel (addr_mux_sel),
   .host_hold    (host_hold)
);

// File: tb/test_mem_pattern_seq.sv
module test_mem_pattern_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        req_normal = 1'b0, req_burst = 1'b0, req_refresh = 1'b0, req_except = 1'b0;
   logic [4:0]  ctl_lines;
   logic        addr_mux_sel, host_hold, seq_busy, wr_reject;
   logic [1:0]  route;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #2 clk = ~clk;

   mem_pattern_seq i_mem_pattern_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .req_normal(req_normal), .req_burst(req_burst), .req_refresh(req_refresh),
      .req_except(req_except), .ctl_lines(ctl_lines), .addr_mux_sel(addr_mux_sel),
      .host_hold(host_hold), .seq_busy(seq_busy), .route(route), .wr_reject(wr_reject)
   );

   // Behavioural reference model
   int unsigned m_mem [64];
   bit          m_busy;
   int          m_pc;
   int          m_route;
   bit          m_rej;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_mem[i]) m_mem[i] = 0;
         m_busy = 0; m_pc = 0; m_route = 0; m_rej = 0;
      end else begin
         m_rej = wr_en && m_busy;
         if (wr_en && !m_busy) m_mem[wr_addr] = wr_data;
         if (m_busy) begin
            if (m_mem[m_pc][7] || m_pc == 63) begin
               m_busy = 0; m_pc = 0; m_route = 0;
            end else m_pc++;
         end else if (req_except)  begin m_busy = 1; m_pc = 60; m_route = 3; end
         else if (req_refresh) begin m_busy = 1; m_pc = 48; m_route = 2; end
         else if (req_burst)   begin m_busy = 1; m_pc = 8;  m_route = 1; end
         else if (req_normal)  begin m_busy = 1; m_pc = 0;  m_route = 0; end
      end
   end

   task automatic chk(string tag, int unsigned act, int unsigned exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int unsigned w;
         w = m_busy ? m_mem[m_pc] : 0;
         chk("R6 busy", seq_busy, m_busy);
         chk(m_busy ? "R5 ctl" : "R2 ctl", ctl_lines, w[4:0]);
         chk(m_busy ? "R5 amux" : "R2 amux", addr_mux_sel, w[5]);
         chk(m_busy ? "R5 hold" : "R2 hold", host_hold, w[6]);
         chk("R11 route", route, m_route);
         chk("R10 reject", wr_reject, m_rej);
      end
   end

   task automatic wr(input int a, input int unsigned d);
      @(negedge clk); wr_en = 1; wr_addr = 6'(a); wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic run(input logic [3:0] rq, input int exp_len, input int exp_route, input string tag);
      int n;
      @(negedge clk);
      {req_except, req_refresh, req_burst, req_normal} = rq;
      @(negedge clk);
      {req_except, req_refresh, req_burst, req_normal} = '0;
      chk({tag, " route"}, route, exp_route);
      n = 0;
      while (seq_busy && n < 100) begin n++; @(negedge clk); end
      chk({tag, " length"}, n, exp_len);
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy", seq_busy, 0);
      chk("R1 ctl", ctl_lines, 0);
      chk("R1 reject", wr_reject, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 idle route", route, 0);
      // R1: empty store, normal run of zero words stops at top
      run(4'b0001, 64, 0, "R1 R8 empty");
      // R9: load routines
      wr(0, 32'h21); wr(1, 32'h43); wr(2, 32'h9F);
      wr(8, 32'h01); wr(9, 32'h22); wr(10, 32'h44); wr(11, 32'h88);
      wr(48, 32'h10); wr(49, 32'h8000_0084);
      wr(60, 32'h11); wr(61, 32'h32); wr(62, 32'h53); wr(63, 32'h74);
      // R3 and R5: single normal
      run(4'b0001, 3, 0, "R3 normal");
      // R4: priority groups; R8: exception has no end flag
      run(4'b1111, 4, 3, "R4 R8 except");
      run(4'b0111, 2, 2, "R4 refresh");
      run(4'b0011, 4, 1, "R4 burst");
      // R7 and R10: requests and write during a burst run
      @(negedge clk); req_burst = 1;
      @(negedge clk); req_burst = 0; req_except = 1; wr_en = 1; wr_addr = 0; wr_data = 32'hFF;
      @(negedge clk); req_except = 0; wr_en = 0;
      chk("R10 reject pulse", wr_reject, 1);
      chk("R7 route kept", route, 1);
      repeat (4) @(negedge clk);
      chk("R7 not remembered", seq_busy, 0);
      // R10: store unchanged, normal still three words with first word 0x21
      @(negedge clk); req_normal = 1;
      @(negedge clk); req_normal = 0;
      chk("R10 store kept", ctl_lines, 5'h01);
      repeat (4) @(negedge clk);
      // R9: write in same cycle as request is seen by the run
      @(negedge clk); req_normal = 1; wr_en = 1; wr_addr = 0; wr_data = 32'h85;
      @(negedge clk); req_normal = 0; wr_en = 0;
      chk("R9 write first", ctl_lines, 5'h05);
      chk("R9 no reject", wr_reject, 0);
      @(negedge clk);
      chk("R6 one word", seq_busy, 0);
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule